// File: doc/BRIEF.md
# Decoupled Fetch Block Sequencer

This block produces the program counter for the main instruction stream of a machine whose control flow is resolved ahead of time by a separate branch engine. The branch engine does not steer fetch directly. It pushes block descriptors into a small queue. Each descriptor holds a start address and the number of instructions in one straight-line run of code. The sequencer takes one descriptor at a time, jumps the PC to its start address and then steps the PC forward by one instruction each time the consumer accepts one. When the run is exhausted, it takes the next descriptor.

The consumer sees a PC together with a valid flag, and it pulses an advance input to accept the instruction at that PC. The producer sees a full flag that tells it to hold off. A descriptor is taken in the cycle after the run count reaches zero. Each new run therefore costs one cycle with no valid PC. A descriptor whose length is zero moves the PC but issues nothing.

Top module: `fetch_block_seq`

## Requirements
- R1: After reset, `pc` equals the `RESET_PC` parameter, `pc_valid` is 0 and `q_full` is 0.
- R2: While the remaining-instruction count is zero and the queue holds a descriptor, the oldest descriptor is removed at the next clock edge. After that edge, `pc` equals its target and the remaining count equals its length.
- R3: While `pc_valid` is 1 and `adv` is 1, the next clock edge adds `INSN_BYTES` (4 by default) to `pc` and lowers the remaining count by one. A block of length L therefore presents exactly L consecutive valid PCs, target + 4*k for k = 0..L-1.
- R4: While `pc_valid` is 1 and `adv` is 0, `pc` and `pc_valid` hold their values.
- R5: `pc_valid` is 1 exactly when the remaining count is nonzero. While the count is zero and the queue is empty, `pc_valid` stays 0, `pc` holds its value and `adv` has no effect.
- R6: A descriptor of length 0 loads its target into `pc`, leaves `pc_valid` at 0, and lets the next descriptor be taken one cycle later.
- R7: `q_full` is 1 when `DEPTH` descriptors are stored. A push while `q_full` is 1 is dropped, and the dropped descriptor never reaches `pc`.
- R8: A push and a removal in the same cycle on a non-empty, non-full queue both take effect. The queue occupancy is unchanged.
- R9: Descriptors reach `pc` in the order they were pushed, under any mix of pushes and advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| enq_valid | input | 1 | Push a descriptor this cycle |
| enq_target | input | PC_W | Start address of the pushed block |
| enq_len | input | LEN_W | Instruction count of the pushed block |
| q_full | output | 1 | Descriptor queue is full |
| adv | input | 1 | Consumer accepts the instruction at `pc` |
| pc | output | PC_W | Current program address |
| pc_valid | output | 1 | `pc` names an instruction to issue |

## Verification
The bench builds the block with `DEPTH` = 4 and `LEN_W` = 4, so blocks are at most 15 instructions long. With these values the queue fills in a handful of pushes, the full flag and the dropped-push path come up often during random traffic, and runs end quickly enough that many descriptor handovers occur. These handovers include zero-length blocks and a push that lands in the same cycle as a removal. The random phase draws lengths from 0 to 5, so empty blocks appear frequently.

// File: rtl/fbs_pkg.sv
package fbs_pkg;
   // bits needed to count 0..n inclusive
   function automatic int unsigned fbs_count_bits(input int unsigned n);
      return $clog2(n + 1);
   endfunction

   // bits needed to address n entries (at least one)
   function automatic int unsigned fbs_addr_bits(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/fbs_desc_fifo.sv
module fbs_desc_fifo
   import fbs_pkg::*;
#(
   parameter int unsigned DEPTH = 8,
   parameter int unsigned DW    = 40,
   localparam int unsigned AW   = fbs_addr_bits(DEPTH),
   localparam int unsigned CW   = fbs_count_bits(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [DW-1:0] wr_data,
   input  logic          rd_en,
   output logic [DW-1:0] rd_data,
   output logic          full,
   output logic          empty,
   output logic [CW-1:0] count
);
   logic [DW-1:0] slot [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic          wr_ok, rd_ok;

   assign full  = (count == CW'(DEPTH));
   assign empty = (count == '0);
   assign wr_ok = wr_en && !full;
   assign rd_ok = rd_en && !empty;
   assign rd_data = slot[rd_ptr];

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_slot
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               slot[i] <= '0;
            else if (wr_ok && (wr_ptr == AW'(i)))
               slot[i] <= wr_data;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (wr_ok) wr_ptr <= wr_ptr + AW'(1);
         if (rd_ok) rd_ptr <= rd_ptr + AW'(1);
         case ({wr_ok, rd_ok})
            2'b10:   count <= count + CW'(1);
            2'b01:   count <= count - CW'(1);
            default: count <= count;
         endcase
      end
   end
endmodule

// File: rtl/fbs_block_walker.sv
module fbs_block_walker #(
   parameter int unsigned    PC_W       = 32,
   parameter int unsigned    LEN_W      = 8,
   parameter int unsigned    INSN_BYTES = 4,
   parameter logic [PC_W-1:0] RESET_PC  = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   input  logic             have_desc,
   input  logic [PC_W-1:0]  desc_tgt,
   input  logic [LEN_W-1:0] desc_len,
   output logic             take,
   output logic [PC_W-1:0]  pc,
   output logic             pc_valid
);
   logic [LEN_W-1:0] remain;
   logic             step;

   assign pc_valid = (remain != '0);
   assign take     = !pc_valid && have_desc;
   assign step     = pc_valid && adv;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc     <= RESET_PC;
         remain <= '0;
      end else if (take) begin
         pc     <= desc_tgt;
         remain <= desc_len;
      end else if (step) begin
         pc     <= pc + PC_W'(INSN_BYTES);
         remain <= remain - LEN_W'(1);
      end
   end
endmodule

// File: rtl/fetch_block_seq.sv
module fetch_block_seq
   import fbs_pkg::*;
#(
   parameter int unsigned     PC_W       = 32,
   parameter int unsigned     LEN_W      = 8,
   parameter int unsigned     DEPTH      = 8,
   parameter int unsigned     INSN_BYTES = 4,
   parameter logic [PC_W-1:0] RESET_PC   = '0,
   localparam int unsigned    DW         = PC_W + LEN_W,
   localparam int unsigned    CW         = fbs_count_bits(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enq_valid,
   input  logic [PC_W-1:0]  enq_target,
   input  logic [LEN_W-1:0] enq_len,
   output logic             q_full,
   input  logic             adv,
   output logic [PC_W-1:0]  pc,
   output logic             pc_valid
);
   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("DEPTH must be a power of two, at least 2");
      end
      if (LEN_W < 1 || PC_W < 2) begin : g_bad_width
         $error("LEN_W must be at least 1 and PC_W at least 2");
      end
      if (INSN_BYTES == 0) begin : g_bad_step
         $error("INSN_BYTES must be nonzero");
      end
   endgenerate

   logic [DW-1:0]    head;
   logic             q_empty;
   logic [CW-1:0]    q_count;
   logic             deq_fire;
   logic [PC_W-1:0]  head_tgt;
   logic [LEN_W-1:0] head_len;

   assign head_tgt = head[DW-1:LEN_W];
   assign head_len = head[LEN_W-1:0];

   fbs_desc_fifo #(.DEPTH(DEPTH), .DW(DW)) u_queue (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (enq_valid),
      .wr_data ({enq_target, enq_len}),
      .rd_en   (deq_fire),
      .rd_data (head),
      .full    (q_full),
      .empty   (q_empty),
      .count   (q_count)
   );

   fbs_block_walker #(
      .PC_W(PC_W), .LEN_W(LEN_W), .INSN_BYTES(INSN_BYTES), .RESET_PC(RESET_PC)
   ) u_walker (
      .clk       (clk),
      .rst_n     (rst_n),
      .adv       (adv),
      .have_desc (!q_empty),
      .desc_tgt  (head_tgt),
      .desc_len  (head_len),
      .take      (deq_fire),
      .pc        (pc),
      .pc_valid  (pc_valid)
   );
endmodule

// File: rtl/fbs_checker.sv
module fbs_checker #(
   parameter int unsigned PC_W       = 32,
   parameter int unsigned LEN_W      = 8,
   parameter int unsigned DEPTH      = 8,
   parameter int unsigned INSN_BYTES = 4,
   parameter int unsigned CW         = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             enq_valid,
   input logic             adv,
   input logic [PC_W-1:0]  pc,
   input logic             pc_valid,
   input logic             q_full,
   input logic             deq,
   input logic [PC_W-1:0]  head_tgt,
   input logic [LEN_W-1:0] head_len,
   input logic [CW-1:0]    q_count
);
   p_load_target_r2: assert property (@(posedge clk) disable iff (!rst_n)
      deq |=> pc == $past(head_tgt));

   p_step_pc_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_valid && adv) |=> pc == $past(pc) + PC_W'(INSN_BYTES));

   p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_valid && !adv) |=> (pc_valid && $stable(pc)));

   p_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!pc_valid && q_count == '0) |=> $stable(pc));

   p_zero_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (deq && head_len == '0) |=> !pc_valid);

   p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (q_full && enq_valid && !deq) |=> q_count == $past(q_count));

   p_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      q_count <= CW'(DEPTH));

   p_swap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (enq_valid && deq && !q_full) |=> q_count == $past(q_count));
endmodule

bind fetch_block_seq fbs_checker #(
   .PC_W(PC_W), .LEN_W(LEN_W), .DEPTH(DEPTH), .INSN_BYTES(INSN_BYTES), .CW(CW)
) u_fbs_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .enq_valid (enq_valid),
   .adv       (adv),
   .pc        (pc),
   .pc_valid  (pc_valid),
   .q_full    (q_full),
   .deq       (deq_fire),
   .head_tgt  (head_tgt),
   .head_len  (head_len),
   .q_count   (q_count)
);

// File: tb/fetch_block_seq_bench.sv
module fetch_block_seq_bench;
   localparam int unsigned PC_W  = 32;
   localparam int unsigned LEN_W = 4;
   localparam int unsigned DEPTH = 4;
   localparam logic [31:0] RST_PC = 32'h0000_0100;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             enq_valid = 1'b0;
   logic [PC_W-1:0]  enq_target = '0;
   logic [LEN_W-1:0] enq_len = '0;
   logic             adv = 1'b0;
   logic             q_full;
   logic [PC_W-1:0]  pc;
   logic             pc_valid;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   // reference state, computed from the requirements
   logic [31:0] m_pc;
   int          m_len;
   logic [31:0] mq_t[$];
   int          mq_l[$];

   always #2.5 clk = ~clk;

   fetch_block_seq #(
      .PC_W(PC_W), .LEN_W(LEN_W), .DEPTH(DEPTH), .INSN_BYTES(4), .RESET_PC(RST_PC)
   ) u_fetch_block_seq (
      .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_target(enq_target),
      .enq_len(enq_len), .q_full(q_full), .adv(adv), .pc(pc), .pc_valid(pc_valid)
   );

   task automatic chk(input string tag, input string name, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", tag, name, act, exp);
      end
   endtask

   task automatic compare(input string tag);
      chk(tag, "pc_valid", {31'b0, pc_valid}, {31'b0, (m_len != 0)});
      chk(tag, "pc", pc, m_pc);
      chk(tag, "q_full", {31'b0, q_full}, {31'b0, (mq_t.size() == DEPTH)});
   endtask

   task automatic step(input string tag);
      bit take, push_ok;
      @(posedge clk);
      push_ok = enq_valid && (mq_t.size() < DEPTH);
      take    = (m_len == 0) && (mq_t.size() > 0);
      if (take) begin
         m_pc  = mq_t.pop_front();
         m_len = mq_l.pop_front();
      end else if (adv && m_len != 0) begin
         m_pc  = m_pc + 32'd4;
         m_len = m_len - 1;
      end
      if (push_ok) begin
         mq_t.push_back(enq_target);
         mq_l.push_back(int'(enq_len));
      end
      @(negedge clk);
      compare(tag);
   endtask

   task automatic push(input string tag, input logic [31:0] t, input int l);
      enq_valid  = 1'b1;
      enq_target = t;
      enq_len    = LEN_W'(l);
      step(tag);
      enq_valid  = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL R9 watchdog actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int unsigned seed_v;
      m_pc  = RST_PC;
      m_len = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1", "pc", pc, RST_PC);
      chk("R1", "pc_valid", {31'b0, pc_valid}, 32'd0);
      chk("R1", "q_full", {31'b0, q_full}, 32'd0);

      // R5 idle with advance pulsing
      adv = 1'b1;
      repeat (3) step("R5");

      // R2/R3/R4 one block of three
      adv = 1'b0;
      push("R2", 32'h1000, 3);
      step("R2");
      chk("R2", "pc_direct", pc, 32'h1000);
      step("R4");
      step("R4");
      adv = 1'b1;
      step("R3");
      chk("R3", "pc_direct", pc, 32'h1004);
      step("R3");
      step("R3");
      chk("R3", "valid_end", {31'b0, pc_valid}, 32'd0);
      repeat (2) step("R5");

      // R6 zero-length block followed by a real one
      adv = 1'b0;
      push("R6", 32'h2000, 0);
      push("R6", 32'h3000, 2);
      chk("R6", "pc_zero", pc, 32'h2000);
      chk("R6", "valid_zero", {31'b0, pc_valid}, 32'd0);
      step("R6");
      chk("R6", "pc_next", pc, 32'h3000);
      adv = 1'b1;
      repeat (3) step("R6");

      // R7 fill while a long block runs, then overfill
      adv = 1'b0;
      push("R7", 32'h4000, 15);
      step("R7");
      for (int i = 0; i < DEPTH + 2; i++) push("R7", 32'h5000 + 32'(i) * 32'h100, 1);
      chk("R7", "q_full_direct", {31'b0, q_full}, 32'd1);
      adv = 1'b1;
      repeat (40) step("R7");

      // R8 push lands in the same cycle as a removal
      adv = 1'b0;
      push("R8", 32'h6000, 1);
      push("R8", 32'h7000, 2);
      push("R8", 32'h8000, 1);
      adv = 1'b1;
      enq_valid = 1'b1; enq_target = 32'h9000; enq_len = 4'd1;
      repeat (2) step("R8");
      enq_valid = 1'b0;
      repeat (12) step("R8");

      // R9 random traffic
      seed_v = $urandom(32'h00C0FFEE);
      for (int n = 0; n < 4000; n++) begin
         enq_valid  = ($urandom_range(0, 9) < 4);
         enq_target = {$urandom_range(0, 32'hFFFF), 2'b00} + 32'h10000;
         enq_len    = LEN_W'($urandom_range(0, 5));
         adv        = ($urandom_range(0, 9) < 7);
         step("R9");
      end
      enq_valid = 1'b0;
      adv = 1'b1;
      repeat (60) step("R9");

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule